// File: doc/BRIEF.md
# DMA Handshake Ready Generator

This block drives the two active-low request lines that one serial channel presents to an external DMA controller: a transmit-ready line (`txrdy_n`) and a receive-ready line (`rxrdy_n`). It does not hold data. It watches the occupancy counts of the channel's transmit and receive FIFOs, plus a receive threshold flag and a receive timeout flag that neighbouring logic raises. From these it decides when the DMA controller should move data in or out.

Two transfer styles are supported. In single-transfer style the lines request one character at a time. Transmit ready is asserted only when the transmit side is completely empty, and receive ready is asserted whenever any character is waiting. In block-transfer style the lines request bursts. Transmit ready is asserted while any free slot exists. Receive ready asserts on threshold or timeout, then stays asserted until the receive FIFO has been drained.

The style is chosen through a small configuration write that carries a FIFO-enable bit and a style bit. Block style is in force only while the FIFOs are enabled. With the FIFOs off, the occupancy inputs describe one-entry holding registers and single-transfer rules apply.

Top module: `dmardy_gen`

## Requirements
- R1: While `rst_n` is low, `txrdy_n` is 0 and `rxrdy_n` is 1. Reset leaves the FIFOs disabled and selects single-transfer style.
- R2: On a cycle with `cfg_we`=1 and `cfg_fifo_en`=1, both the FIFO-enable state and the style bit are loaded. `cfg_blk_mode`=1 selects block style and 0 selects single-transfer style.
- R3: On a cycle with `cfg_we`=1 and `cfg_fifo_en`=0, the FIFOs become disabled. In that case `cfg_blk_mode` has no effect, and the outputs follow single-transfer rules whatever its value.
- R4: In single-transfer style, `txrdy_n` is 0 when `tx_count` is 0 and 1 when `tx_count` is nonzero.
- R5: In single-transfer style, `rxrdy_n` is 0 when `rx_count` is nonzero and 1 when `rx_count` is 0.
- R6: In block style, `txrdy_n` is 1 only when `tx_count` equals DEPTH (16 by default), and 0 otherwise.
- R7: In block style, with `rx_count` nonzero, `rx_thresh_hit`=1 or `rx_timeout`=1 drives `rxrdy_n` to 0.
- R8: In block style, with `rx_count` nonzero and both flags 0, `rxrdy_n` keeps its previous level. It therefore stays 0 after the flags drop, and a nonzero count alone does not assert it.
- R9: In block style, `rx_count` equal to 0 drives `rxrdy_n` to 1, even when a flag is raised in the same cycle.
- R10: Both outputs are registered and reflect the inputs of the previous clock edge. A configuration write takes effect on the outputs one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | FIFO-enable bit of the configuration write |
| cfg_blk_mode | input | 1 | Style bit of the configuration write (1 = block) |
| tx_count | input | CW (5) | Transmit FIFO occupancy, 0..DEPTH |
| rx_count | input | CW (5) | Receive FIFO occupancy, 0..DEPTH |
| rx_thresh_hit | input | 1 | Receive occupancy has reached its threshold |
| rx_timeout | input | 1 | Receive timeout has fired |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |

## Verification
In block style, the receive release on an empty FIFO and the receive assertion from a threshold or timeout flag can arrive in the same cycle. The bench provokes this directly, by raising the timeout with a zero count, and randomly, by drawing the flags independently of the counts. It judges the result against a model in which emptiness wins. A configuration write can also coincide with an occupancy change. That case is judged by expecting the old style's rule on the first edge and the new style's rule on the following one.

// File: rtl/dmardy_pkg.sv
// Package: shared types for the DMA ready generator.
// Assumes nothing beyond IEEE 1800-2017.
package dmardy_pkg;

    // Transfer style selected by the configuration style bit.
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BLOCK  = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/dmardy_cfg.sv
// Module: dmardy_cfg
// Holds the FIFO-enable state and the transfer style. A write with the
// enable bit clear only disables the FIFOs; the style bit is loaded only
// by a write that also sets the enable bit. Block style is reported only
// while the FIFOs are enabled.
// Assumes: synchronous active-low reset, write strobe is one cycle wide.
module dmardy_cfg
    import dmardy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_fifo_en,
    input  logic cfg_blk_mode,
    output logic blk_mode
);

    logic       fifo_en_q;
    xfer_mode_e mode_q;

    // Capture the configuration bits on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en_q <= 1'b0;
            mode_q    <= XFER_SINGLE;
        end else if (cfg_we) begin
            fifo_en_q <= cfg_fifo_en;
            if (cfg_fifo_en) begin
                mode_q <= cfg_blk_mode ? XFER_BLOCK : XFER_SINGLE;
            end
        end
    end

    // Block style applies only with the FIFOs enabled.
    always_comb begin
        blk_mode = fifo_en_q && (mode_q == XFER_BLOCK);
    end

endmodule

// File: rtl/dmardy_tx.sv
// Module: dmardy_tx
// Produces the registered active-low transmit request. Single style
// requests when the transmit side holds nothing; block style requests
// while at least one slot is free.
// Assumes: tx_count never exceeds DEPTH.
module dmardy_tx #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_mode,
    input  logic [CW-1:0] tx_count,
    output logic          txrdy_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic tx_empty;
    logic tx_full;
    logic txrdy_n_d;

    // Occupancy decode.
    always_comb begin
        tx_empty = (tx_count == '0);
        tx_full  = (tx_count == FULL_CNT);
    end

    // Select the rule of the active style.
    always_comb begin
        if (blk_mode) begin
            txrdy_n_d = tx_full;
        end else begin
            txrdy_n_d = !tx_empty;
        end
    end

    // Register the request; reset asserts it (empty transmitter).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txrdy_n <= 1'b0;
        end else begin
            txrdy_n <= txrdy_n_d;
        end
    end

endmodule

// File: rtl/dmardy_rx.sv
// Module: dmardy_rx
// Produces the registered active-low receive request. Single style
// requests whenever data waits. Block style sets the request on a
// threshold or timeout flag and clears it only when the FIFO is empty;
// emptiness wins over a flag in the same cycle.
// Assumes: rx_count never exceeds DEPTH.
module dmardy_rx #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_mode,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_thresh_hit,
    input  logic          rx_timeout,
    output logic          rxrdy_n
);

    logic rx_empty;
    logic burst_set;
    logic rxrdy_n_d;

    // Occupancy and event decode.
    always_comb begin
        rx_empty  = (rx_count == '0);
        burst_set = rx_thresh_hit || rx_timeout;
    end

    // Select the rule of the active style.
    always_comb begin
        rxrdy_n_d = rxrdy_n;
        if (!blk_mode) begin
            rxrdy_n_d = rx_empty;
        end else if (rx_empty) begin
            rxrdy_n_d = 1'b1;
        end else if (burst_set) begin
            rxrdy_n_d = 1'b0;
        end
    end

    // Register the request; reset deasserts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxrdy_n <= 1'b1;
        end else begin
            rxrdy_n <= rxrdy_n_d;
        end
    end

endmodule

// File: rtl/dmardy_gen.sv
// Module: dmardy_gen (top)
// DMA handshake ready generator for one serial channel: configuration
// holder plus one request generator per direction.
// Assumes: occupancy counts are synchronous to clk and within 0..DEPTH.
module dmardy_gen #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic          cfg_blk_mode,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    input  logic          rx_thresh_hit,
    input  logic          rx_timeout,
    output logic          txrdy_n,
    output logic          rxrdy_n
);

    logic blk_mode;

    dmardy_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_fifo_en  (cfg_fifo_en),
        .cfg_blk_mode (cfg_blk_mode),
        .blk_mode     (blk_mode)
    );

    dmardy_tx #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .tx_count (tx_count),
        .txrdy_n  (txrdy_n)
    );

    dmardy_rx #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .blk_mode      (blk_mode),
        .rx_count      (rx_count),
        .rx_thresh_hit (rx_thresh_hit),
        .rx_timeout    (rx_timeout),
        .rxrdy_n       (rxrdy_n)
    );

endmodule

// File: rtl/dmardy_gen_chk.sv
// Module: dmardy_gen_chk
// Property checker bound to dmardy_gen; observes ports plus the style
// signal passed between the configuration holder and the generators.
module dmardy_gen_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          cfg_fifo_en,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          rx_thresh_hit,
    input logic          rx_timeout,
    input logic          blk_mode,
    input logic          txrdy_n,
    input logic          rxrdy_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!txrdy_n && rxrdy_n));

    p_disable_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_fifo_en) |=> !blk_mode);

    p_single_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode |=> (txrdy_n == ($past(tx_count) != '0)));

    p_single_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode |=> (rxrdy_n == ($past(rx_count) == '0)));

    p_block_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_mode |=> (txrdy_n == ($past(tx_count) == FULL_CNT)));

    p_block_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rx_count != '0 && (rx_thresh_hit || rx_timeout)) |=> !rxrdy_n);

    p_block_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rx_count != '0 && !rx_thresh_hit && !rx_timeout) |=> $stable(rxrdy_n));

    p_block_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rx_count == '0) |=> rxrdy_n);

endmodule

bind dmardy_gen dmardy_gen_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_fifo_en   (cfg_fifo_en),
    .tx_count      (tx_count),
    .rx_count      (rx_count),
    .rx_thresh_hit (rx_thresh_hit),
    .rx_timeout    (rx_timeout),
    .blk_mode      (blk_mode),
    .txrdy_n       (txrdy_n),
    .rxrdy_n       (rxrdy_n)
);

// File: tb/dmardy_gen_tb_top.sv
// Bench for dmardy_gen: directed corner cases then seeded random cycles,
// checked against a requirement-level reference model.
module dmardy_gen_tb_top;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic          cfg_fifo_en;
    logic          cfg_blk_mode;
    logic [CW-1:0] tx_count;
    logic [CW-1:0] rx_count;
    logic          rx_thresh_hit;
    logic          rx_timeout;
    logic          txrdy_n;
    logic          rxrdy_n;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    // Reference model state.
    bit m_en   = 1'b0;
    bit m_mode = 1'b0;
    bit e_tx   = 1'b0;
    bit e_rx   = 1'b1;

    always #10 clk = ~clk;

    dmardy_gen #(.DEPTH(DEPTH), .CW(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_fifo_en   (cfg_fifo_en),
        .cfg_blk_mode  (cfg_blk_mode),
        .tx_count      (tx_count),
        .rx_count      (rx_count),
        .rx_thresh_hit (rx_thresh_hit),
        .rx_timeout    (rx_timeout),
        .txrdy_n       (txrdy_n),
        .rxrdy_n       (rxrdy_n)
    );

    function automatic bit exp_tx(bit blk, int cnt);
        return blk ? (cnt == DEPTH) : (cnt != 0);
    endfunction

    function automatic bit exp_rx(bit blk, int cnt, bit thr, bit tmo, bit prev);
        if (!blk)          return (cnt == 0);
        if (cnt == 0)      return 1'b1;
        if (thr || tmo)    return 1'b0;
        return prev;
    endfunction

    task automatic check(string req, string sig, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, sig, act, exp, $time);
        end
    endtask

    // Advance one edge with the driven inputs, then compare both outputs.
    task automatic cycle(string txreq, string rxreq);
        bit blk;
        blk  = m_en && m_mode;
        e_tx = exp_tx(blk, int'(tx_count));
        e_rx = exp_rx(blk, int'(rx_count), rx_thresh_hit, rx_timeout, e_rx);
        if (cfg_we) begin
            m_en = cfg_fifo_en;
            if (cfg_fifo_en) m_mode = cfg_blk_mode;
        end
        @(negedge clk);
        check(txreq, "txrdy_n", txrdy_n, e_tx);
        check(rxreq, "rxrdy_n", rxrdy_n, e_rx);
        cfg_we = 1'b0;
    endtask

    task automatic drive(int txc, int rxc, bit thr, bit tmo);
        tx_count      = CW'(txc);
        rx_count      = CW'(rxc);
        rx_thresh_hit = thr;
        rx_timeout    = tmo;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_fifo_en = 1'b0; cfg_blk_mode = 1'b0;
        drive(5, 3, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R1", "txrdy_n", txrdy_n, 1'b0);
        check("R1", "rxrdy_n", rxrdy_n, 1'b1);
        drive(0, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cycle("R1", "R1");

        // R4 / R5: single-transfer rules.
        drive(3, 2, 1'b0, 1'b0);   cycle("R4", "R5");
        drive(0, 0, 1'b0, 1'b0);   cycle("R4", "R5");
        drive(DEPTH, 1, 1'b0, 1'b0); cycle("R4", "R5");

        // R3: write with enable clear, style bit set: single rules remain.
        cfg_we = 1'b1; cfg_fifo_en = 1'b0; cfg_blk_mode = 1'b1;
        drive(5, 0, 1'b0, 1'b0);   cycle("R3", "R3");
        drive(5, 4, 1'b1, 1'b0);   cycle("R3", "R3");
        drive(0, 0, 1'b0, 1'b0);   cycle("R3", "R3");

        // R2 / R10: enable block style; old rule applies on the first edge.
        cfg_we = 1'b1; cfg_fifo_en = 1'b1; cfg_blk_mode = 1'b1;
        drive(5, 0, 1'b0, 1'b0);   cycle("R10", "R10");
        drive(5, 0, 1'b0, 1'b0);   cycle("R2", "R2");

        // R6: block transmit tracks full.
        drive(DEPTH, 0, 1'b0, 1'b0);     cycle("R6", "R9");
        drive(DEPTH - 1, 0, 1'b0, 1'b0); cycle("R6", "R9");

        // R7 / R8 / R9: block receive latch.
        drive(0, 3, 1'b0, 1'b0);   cycle("R6", "R8");
        drive(0, 4, 1'b1, 1'b0);   cycle("R6", "R7");
        drive(0, 2, 1'b0, 1'b0);   cycle("R6", "R8");
        drive(0, 1, 1'b0, 1'b1);   cycle("R6", "R7");
        drive(0, 0, 1'b0, 1'b1);   cycle("R6", "R9");
        drive(0, 1, 1'b0, 1'b0);   cycle("R6", "R8");

        // Seeded random phase with occasional configuration writes.
        void'($urandom(32'd2718));
        for (int i = 0; i < 3000; i++) begin
            bit blk;
            drive(int'($urandom_range(DEPTH, 0)), int'($urandom_range(DEPTH, 0)),
                  ($urandom_range(3, 0) == 0), ($urandom_range(5, 0) == 0));
            if ($urandom_range(15, 0) == 0) begin
                cfg_we       = 1'b1;
                cfg_fifo_en  = 1'($urandom_range(1, 0));
                cfg_blk_mode = 1'($urandom_range(1, 0));
            end
            if ($urandom_range(7, 0) == 0) tx_count = CW'(DEPTH);
            if ($urandom_range(7, 0) == 0) rx_count = '0;
            blk = m_en && m_mode;
            if (blk) cycle("R6", "R7");
            else     cycle("R4", "R5");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule